// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC, between the byte stream from the line side and the receive DMA. It watches the first six bytes of each frame, which hold the destination address, and decides whether the frame should be kept. The decision is registered and held steady, so the downstream logic can sample it at any time until the next frame begins.

The filter keeps its own settings in a small set of 32-bit registers, written through a simple write port. The settings are the station's own address, a 64-entry multicast hash table and four control bits: receive enable, promiscuous, pass-all-group and hash enable. A frame is kept if any of these hold:

- promiscuous mode is on;
- the destination equals the station address;
- the destination is the all-ones broadcast address;
- the destination is a group address, and either pass-all-group is set or its hash bit is set with hashing enabled.

Software clears receive enable while it rewrites the tables and sets it again afterwards.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `flt_done` and `flt_accept` are 0 and every register reads as zero, so receive enable is off and frames are rejected until software turns it on.
- R2: A beat is a cycle with `rx_valid`=1, and a beat with `rx_sof`=1 carries address byte 0. Beats count in order, and cycles with `rx_valid`=0 are not counted. `flt_done` goes to 1 one cycle after the beat carrying byte 5, and `flt_accept` holds the decision in that same cycle. `flt_accept` is never 1 while `flt_done` is 0.
- R3: Once set, `flt_done` and `flt_accept` hold their values through any later payload beats. The cycle after the next beat with `rx_sof`=1, both read 0.
- R4: The station address is held in two registers. Offset 1 holds bytes 0..3, with byte 0 in bits 7:0, byte 1 in 15:8, and so on. Offset 2 holds byte 4 in bits 7:0 and byte 5 in bits 15:8. A destination equal to the station address in all six bytes is accepted. A unicast destination that differs in any byte is rejected unless promiscuous mode is on.
- R5: The broadcast destination (all six bytes 0xFF) is accepted whenever receive enable is on.
- R6: The hash index is bits 31:26 of a CRC-32 taken over the six destination bytes. The CRC uses polynomial 0x04C11DB7 and a preset of all ones, with no final inversion. Each byte is fed least significant bit first, and for each bit the register shifts toward bit 31, with the polynomial XORed in when (bit 31 XOR data bit) is 1. The table is bit `idx[4:0]` of offset 3 when `idx[5]`=0, or of offset 4 when `idx[5]`=1. A group destination (bit 0 of byte 0 set) whose table bit is 1 is accepted only while hash enable is set. A unicast destination is never accepted through the table.
- R7: With pass-all-group set, every group destination is accepted whatever the table holds. Unicast destinations still need the station match.
- R8: With promiscuous set, every destination is accepted.
- R9: With receive enable clear, every frame is rejected (`flt_done`=1, `flt_accept`=0), whatever the other settings.
- R10: Offset 0 is the control register: bit 0 receive enable, bit 1 promiscuous, bit 2 pass-all-group, bit 3 hash enable. A write takes effect on the next clock edge. Writes to offsets 5 to 7 change nothing.
- R11: A beat with `rx_sof`=1 arriving before the sixth address byte restarts the address collection. Only the bytes of the new frame decide the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word offset |
| cfg_wdata | input | CFG_DW | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| flt_done | output | 1 | Decision available for the current frame |
| flt_accept | output | 1 | Frame accepted (meaningful while flt_done is 1) |

## Verification
A corrupted CRC register or a wrong hash bit select shows up only for group addresses, as a wrong `flt_accept` in the cycle right after the sixth address byte. Sweeping one byte across all 64 values against two complementary tables exposes it within the sweep. A byte counter that counts idle cycles, misses a restart, or overruns moves or suppresses the rise of `flt_done`. That is visible the first time a gap or an early start-of-frame appears. Errors in hold or clear appear as `flt_accept` changing during payload beats, or as `flt_done` still high one cycle after a new start-of-frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int CRC_W      = 32;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_SIZE  = 1 << HASH_IDX_W;
  localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET = '1;

  localparam int OFS_CTRL    = 0;
  localparam int OFS_STA_LO  = 1;
  localparam int OFS_STA_HI  = 2;
  localparam int OFS_HASH_LO = 3;
  localparam int OFS_HASH_HI = 4;

  localparam int CTL_RXEN  = 0;
  localparam int CTL_PROM  = 1;
  localparam int CTL_ALLG  = 2;
  localparam int CTL_HASHE = 3;

  typedef struct packed {
    logic                 rx_en;
    logic                 promisc;
    logic                 all_group;
    logic                 hash_en;
    logic [ADDR_W-1:0]    station;
    logic [HASH_SIZE-1:0] table_bits;
  } rxf_cfg_t;

  // One byte of the address CRC, bits taken least significant first.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output rxf_cfg_t          cfg
);

  localparam int HI_BYTES = ADDR_BYTES - 4;
  localparam int HI_W     = HI_BYTES * 8;

  logic [3:0]        ctrl_q;
  logic [31:0]       sta_lo_q;
  logic [HI_W-1:0]   sta_hi_q;
  logic [31:0]       hash_lo_q;
  logic [31:0]       hash_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      sta_lo_q  <= '0;
      sta_hi_q  <= '0;
      hash_lo_q <= '0;
      hash_hi_q <= '0;
    end else if (we) begin
      case (int'(addr))
        OFS_CTRL:    ctrl_q    <= wdata[3:0];
        OFS_STA_LO:  sta_lo_q  <= wdata[31:0];
        OFS_STA_HI:  sta_hi_q  <= wdata[HI_W-1:0];
        OFS_HASH_LO: hash_lo_q <= wdata[31:0];
        OFS_HASH_HI: hash_hi_q <= wdata[31:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.rx_en      = ctrl_q[CTL_RXEN];
    cfg.promisc    = ctrl_q[CTL_PROM];
    cfg.all_group  = ctrl_q[CTL_ALLG];
    cfg.hash_en    = ctrl_q[CTL_HASHE];
    cfg.station    = {sta_hi_q, sta_lo_q};
    cfg.table_bits = {hash_hi_q, hash_lo_q};
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && int'(addr) == OFS_CTRL) |=> (cfg.rx_en == $past(wdata[CTL_RXEN]) &&
                                         cfg.promisc == $past(wdata[CTL_PROM]))) // R10
    else $error("control write not applied");

  AST_UNUSED_OFS: assert property (@(posedge clk) disable iff (rst)
    (we && int'(addr) > OFS_HASH_HI) |=> $stable(cfg)) // R10
    else $error("unused offset changed settings");

endmodule

// File: rtl/rxf_addr_track.sv
module rxf_addr_track
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  output logic              sof_beat,
  output logic              fin,
  output logic [ADDR_W-1:0] addr_full,
  output logic [CRC_W-1:0]  crc_full
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic             take;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;
  logic [7:0]       byte_q [ADDR_BYTES];

  assign sof_beat = in_valid & in_sof;
  assign pos      = sof_beat ? '0 : cnt_q;
  assign take     = in_valid && (pos < IDLE);
  assign fin      = take && (pos == LAST);
  assign crc_nxt  = crc_byte(sof_beat ? CRC_PRESET : crc_q, in_data[7:0]);
  assign crc_full = crc_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= IDLE;
      crc_q <= CRC_PRESET;
    end else if (take) begin
      cnt_q <= pos + 1'b1;
      crc_q <= crc_nxt;
    end
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) byte_q[i] <= '0;
      else if (take && pos == CNT_W'(i)) byte_q[i] <= in_data[7:0];
    end
    // The last byte is taken straight from the input so the decision needs no extra cycle.
    assign addr_full[i*8 +: 8] = (take && pos == CNT_W'(i)) ? in_data[7:0] : byte_q[i];
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= IDLE) // R2
    else $error("byte counter out of range");

  AST_SINGLE_FIN: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin) // R2
    else $error("two completions back to back");

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cnt_q)) // R2
    else $error("counter moved without a beat");

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  rxf_cfg_t          cfg,
  input  logic              sof_beat,
  input  logic              fin,
  input  logic [ADDR_W-1:0] addr_full,
  input  logic [CRC_W-1:0]  crc_full,
  output logic              done,
  output logic              accept
);

  logic [HASH_IDX_W-1:0] idx;
  logic is_group, is_bcast, is_station, hash_hit, verdict;

  assign idx        = crc_full[CRC_W-1 -: HASH_IDX_W];
  assign is_group   = addr_full[0];
  assign is_bcast   = &addr_full;
  assign is_station = (addr_full == cfg.station);
  assign hash_hit   = cfg.hash_en & cfg.table_bits[idx];
  assign verdict    = cfg.rx_en &
                      (cfg.promisc | is_station | is_bcast |
                       (is_group & (cfg.all_group | hash_hit)));

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      accept <= 1'b0;
    end else if (fin) begin
      done   <= 1'b1;
      accept <= verdict;
    end else if (sof_beat) begin
      done   <= 1'b0;
      accept <= 1'b0;
    end
  end

  AST_ACC_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    accept |-> done) // R2
    else $error("accept without done");

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !sof_beat && !fin) |=> (done && $stable(accept))) // R3
    else $error("decision not held");

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sof_beat && !fin) |=> !done) // R3
    else $error("start of frame did not clear decision");

  AST_RX_OFF_REJECT: assert property (@(posedge clk) disable iff (rst)
    (fin && !cfg.rx_en) |=> !accept) // R9
    else $error("accepted with receiver off");

  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (fin && cfg.rx_en && cfg.promisc) |=> accept) // R8
    else $error("promiscuous frame rejected");

  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (fin && cfg.rx_en && (&addr_full)) |=> accept) // R5
    else $error("broadcast rejected");

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  output logic              flt_done,
  output logic              flt_accept
);

  rxf_cfg_t          cfg;
  logic              sof_beat;
  logic              fin;
  logic [ADDR_W-1:0] addr_full;
  logic [CRC_W-1:0]  crc_full;

  rxf_cfg_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  rxf_addr_track #(.DATA_W(8)) u_track (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rx_valid),
    .in_sof    (rx_sof),
    .in_data   (rx_data),
    .sof_beat  (sof_beat),
    .fin       (fin),
    .addr_full (addr_full),
    .crc_full  (crc_full)
  );

  rxf_decide u_decide (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .sof_beat  (sof_beat),
    .fin       (fin),
    .addr_full (addr_full),
    .crc_full  (crc_full),
    .done      (flt_done),
    .accept    (flt_accept)
  );

endmodule

// File: tb/rx_dest_filter_bench.sv
`timescale 1ns/1ps
module rx_dest_filter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        flt_done;
  logic        flt_accept;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rx_dest_filter u_rx_dest_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .flt_done(flt_done), .flt_accept(flt_accept)
  );

  localparam logic [47:0] STA = 48'h5544_3322_1102; // byte0 = 0x02
  localparam logic [63:0] PAT = 64'hA5C3_0F96_3C5A_F00F;

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(ofs); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Hash index from R6: bits enter LSB first within each byte, byte 0 first.
  function automatic int hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic top = c[31];
      c = c << 1;
      if (top ^ a[k]) c = c ^ 32'h04C1_1DB7;
    end
    return int'(c[31:26]);
  endfunction

  // Drive six address bytes; optional idle gap before byte 3; optionally check done low before last edge.
  task automatic send_addr(input logic [47:0] a, input bit gap, input bit pre);
    for (int i = 0; i < 6; i++) begin
      if (gap && i == 3) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_data = 8'hEE;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = a[i*8 +: 8];
      if (pre && i == 5) check(flt_done, 1'b0, "R2 done low before sixth byte edge");
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a, input logic exp, input string tag);
    send_addr(a, 1'b0, 1'b0);
    check(flt_done, 1'b1, {tag, " done"});
    check(flt_accept, exp, tag);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(flt_done, 1'b0, "R1 done after reset");
    check(flt_accept, 1'b0, "R1 accept after reset");
    frame(48'hFFFF_FFFF_FFFF, 1'b0, "R1 receive off after reset");

    wr(1, STA[31:0]);
    wr(2, {16'h0, STA[47:32]});
    frame(STA, 1'b0, "R9 station with receive off");
    wr(0, 32'h1);

    send_addr(STA, 1'b0, 1'b1);
    check(flt_done, 1'b1, "R2 done one cycle after sixth byte");
    check(flt_accept, 1'b1, "R4 station match");

    // R3: payload beats do not disturb decision; sof clears it
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'(i * 37);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    check(flt_done, 1'b1, "R3 done held through payload");
    check(flt_accept, 1'b1, "R3 accept held through payload");
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h00;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    check(flt_done, 1'b0, "R3 done cleared after sof");
    check(flt_accept, 1'b0, "R3 accept cleared after sof");

    send_addr(STA, 1'b1, 1'b0);
    check(flt_done, 1'b1, "R2 done with idle gap");
    check(flt_accept, 1'b1, "R2 accept with idle gap");

    for (int p = 0; p < 6; p++)
      frame(STA ^ (48'h80 << (8 * p)), 1'b0, "R4 station mismatch");

    frame(48'hFFFF_FFFF_FFFF, 1'b1, "R5 broadcast");

    // R6 hash sweep with complementary tables
    wr(0, 32'h9);
    for (int t = 0; t < 2; t++) begin
      logic [63:0] tb = (t == 0) ? PAT : ~PAT;
      wr(3, tb[31:0]);
      wr(4, tb[63:32]);
      for (int k = 0; k < 64; k++) begin
        logic [47:0] a = {8'(k), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
        frame(a, tb[hidx(a)], "R6 hash lookup");
      end
    end
    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    frame(48'h0A0B_0C0D_0E10, 1'b0, "R6 unicast ignores table");
    frame(48'h0A0B_0C0D_0E11, 1'b1, "R6 group hit full table");
    wr(0, 32'h1);
    frame(48'h0A0B_0C0D_0E11, 1'b0, "R6 hash disabled");

    wr(3, 32'h0);
    wr(4, 32'h0);
    wr(0, 32'h5);
    frame(48'h0A0B_0C0D_0E11, 1'b1, "R7 pass-all group");
    frame(48'h7700_0000_0033, 1'b1, "R7 pass-all group 2");
    frame(48'h0A0B_0C0D_0E10, 1'b0, "R7 unicast still filtered");

    wr(0, 32'h3);
    frame(48'h0A0B_0C0D_0E10, 1'b1, "R8 promiscuous unicast");
    frame(48'h0000_0000_0000, 1'b1, "R8 promiscuous zero address");

    wr(0, 32'hE);
    frame(48'hFFFF_FFFF_FFFF, 1'b0, "R9 receive off overrides all");

    wr(0, 32'h1);
    wr(5, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    frame(48'h0A0B_0C0D_0E10, 1'b0, "R10 unused offsets no effect");
    frame(48'h0A0B_0C0D_0E11, 1'b0, "R10 unused offsets no group effect");
    frame(STA, 1'b1, "R10 station kept");

    // R11: partial frame then restart
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = 8'hC3;
    end
    frame(STA, 1'b1, "R11 restart to station");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = STA[i*8 +: 8];
    end
    frame(48'h0A0B_0C0D_0E10, 1'b0, "R11 restart to stranger");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule